// File: doc/BRIEF.md
# AXI4-Stream Ingress Holding Register

This block sits between an external AXI4-Stream sender and a processing pipeline that cannot stall. It passes each beat to the pipeline. The beat carries valid, data, last, id, dest, user, keep and strb. A ready signal comes back from a downstream egress stage. When that ready drops, the block cuts its internal valid in the same cycle. No new beat enters the pipeline. The external ready is a registered copy of the downstream ready, so it falls one cycle later. One holding register catches any beat that the sender completes during that late cycle.

When the downstream ready returns, the held beat goes out first. The external ready comes back one cycle after that. Field widths are parameters. Each optional sideband field can be switched off, and a switched-off field is driven with its protocol default value.

Top module: `axis_ingress_hold`

## Requirements
- R1: In any cycle in which `p_ready` is low, `p_valid` is low in that same cycle.
- R2: `s_ready` equals the value `p_ready` had in the previous clock cycle, and `s_ready` is high in the first cycle after reset.
- R3: With the holding register empty, a beat accepted while `p_ready` is high appears on the internal port in the same cycle, with every field unchanged.
- R4: A beat accepted (`s_valid` and `s_ready` high at a rising edge) while `p_ready` is low is stored, all fields included. It is the first beat presented once `p_ready` is high again.
- R5: While the holding register is full, `s_ready` is low, so no further external beat is accepted.
- R6: Every accepted beat is delivered internally exactly once, in acceptance order. A cycle with `s_valid` low and nothing held produces no internal beat.
- R7: A disabled optional field is driven with its default value, whatever its input pin carries. The keep and strb defaults are all ones, the last default is 1, and the id, dest and user defaults are zero.
- R8: A synchronous active-high `rst` empties the holding register and leaves `s_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | External beat valid |
| s_data | input | DATA_W | External beat data |
| s_last | input | 1 | External end-of-packet marker |
| s_id | input | ID_W | External stream identifier |
| s_dest | input | DEST_W | External routing field |
| s_user | input | USER_W | External user sideband |
| s_keep | input | DATA_W/8 | External byte-keep mask |
| s_strb | input | DATA_W/8 | External byte-strobe mask |
| s_ready | output | 1 | Ready returned to the external sender |
| p_valid | output | 1 | Internal beat valid |
| p_data | output | DATA_W | Internal beat data |
| p_last | output | 1 | Internal end-of-packet marker |
| p_id | output | ID_W | Internal stream identifier |
| p_dest | output | DEST_W | Internal routing field |
| p_user | output | USER_W | Internal user sideband |
| p_keep | output | DATA_W/8 | Internal byte-keep mask |
| p_strb | output | DATA_W/8 | Internal byte-strobe mask |
| p_ready | input | 1 | Ready from the downstream egress stage |

## Verification
Four properties are checked on every cycle:
- the internal valid is gated by the downstream ready;
- the external ready lags the downstream ready by exactly one cycle;
- a handshake taken under backpressure always fills the holding register, and never while it is already full;
- a full register forces the external ready low and puts a valid beat out as soon as ready returns.

Only the bench's scenarios show that the beat order and the exactly-once delivery hold across random stalls, and that the field contents survive the hold. The default values on disabled fields and the reset of a full register are also shown only there.

// File: rtl/axis_hold_pkg.sv
package axis_hold_pkg;

  // number of byte lanes for a data width
  function automatic int lane_count(input int data_w);
    return (data_w + 7) / 8;
  endfunction

  // total packed width of one beat: last, id, dest, user, keep, strb, data
  function automatic int beat_width(input int data_w, input int id_w,
                                    input int dest_w, input int user_w);
    return 1 + id_w + dest_w + user_w + 2 * lane_count(data_w) + data_w;
  endfunction

  // an external handshake completes this cycle
  function automatic logic handshake(input logic valid, input logic ready);
    return valid & ready;
  endfunction

endpackage

// File: rtl/axis_field_tie.sv
module axis_field_tie #(
  parameter int W       = 1,
  parameter bit USE     = 1'b1,
  parameter bit DEF_ONE = 1'b0
) (
  input  logic [W-1:0] in_f,
  output logic [W-1:0] out_f
);
  localparam logic [W-1:0] DEF_VAL = DEF_ONE ? {W{1'b1}} : {W{1'b0}};

  assign out_f = USE ? in_f : DEF_VAL;
endmodule

// File: rtl/axis_ready_reg.sv
module axis_ready_reg (
  input  logic clk,
  input  logic rst,
  input  logic p_ready,
  output logic s_ready
);
  always_ff @(posedge clk) begin
    if (rst) s_ready <= 1'b1;
    else     s_ready <= p_ready;
  end

  assert_ready_lag_R2: assert property (@(posedge clk) disable iff (rst)
    p_ready |=> s_ready);
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !p_ready |=> !s_ready);
endmodule

// File: rtl/axis_hold_reg.sv
module axis_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic         rel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (cap) begin
      full <= 1'b1;
    end else if (rel) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) q <= d;
  end

  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
    full |-> !cap);
  assert_filled_R4: assert property (@(posedge clk) disable iff (rst)
    cap |=> full);
endmodule

// File: rtl/axis_ingress_hold.sv
module axis_ingress_hold
  import axis_hold_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int DEST_W   = 4,
  parameter int USER_W   = 2,
  parameter bit USE_LAST = 1'b1,
  parameter bit USE_ID   = 1'b1,
  parameter bit USE_DEST = 1'b1,
  parameter bit USE_USER = 1'b1,
  parameter bit USE_KEEP = 1'b1,
  parameter bit USE_STRB = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              s_valid,
  input  logic [DATA_W-1:0]                 s_data,
  input  logic                              s_last,
  input  logic [ID_W-1:0]                   s_id,
  input  logic [DEST_W-1:0]                 s_dest,
  input  logic [USER_W-1:0]                 s_user,
  input  logic [lane_count(DATA_W)-1:0]     s_keep,
  input  logic [lane_count(DATA_W)-1:0]     s_strb,
  output logic                              s_ready,
  output logic                              p_valid,
  output logic [DATA_W-1:0]                 p_data,
  output logic                              p_last,
  output logic [ID_W-1:0]                   p_id,
  output logic [DEST_W-1:0]                 p_dest,
  output logic [USER_W-1:0]                 p_user,
  output logic [lane_count(DATA_W)-1:0]     p_keep,
  output logic [lane_count(DATA_W)-1:0]     p_strb,
  input  logic                              p_ready
);
  localparam int LANES = lane_count(DATA_W);
  localparam int BW    = beat_width(DATA_W, ID_W, DEST_W, USER_W);

  logic              t_last;
  logic [ID_W-1:0]   t_id;
  logic [DEST_W-1:0] t_dest;
  logic [USER_W-1:0] t_user;
  logic [LANES-1:0]  t_keep;
  logic [LANES-1:0]  t_strb;

  axis_field_tie #(.W(1),      .USE(USE_LAST), .DEF_ONE(1'b1)) u_last (.in_f(s_last), .out_f(t_last));
  axis_field_tie #(.W(ID_W),   .USE(USE_ID),   .DEF_ONE(1'b0)) u_id   (.in_f(s_id),   .out_f(t_id));
  axis_field_tie #(.W(DEST_W), .USE(USE_DEST), .DEF_ONE(1'b0)) u_dest (.in_f(s_dest), .out_f(t_dest));
  axis_field_tie #(.W(USER_W), .USE(USE_USER), .DEF_ONE(1'b0)) u_user (.in_f(s_user), .out_f(t_user));
  axis_field_tie #(.W(LANES),  .USE(USE_KEEP), .DEF_ONE(1'b1)) u_keep (.in_f(s_keep), .out_f(t_keep));
  axis_field_tie #(.W(LANES),  .USE(USE_STRB), .DEF_ONE(1'b1)) u_strb (.in_f(s_strb), .out_f(t_strb));

  // named internal events
  logic          ext_accept;
  logic          hold_cap;
  logic          hold_rel;
  logic          hold_full;
  logic [BW-1:0] ext_beat;
  logic [BW-1:0] held_beat;
  logic [BW-1:0] out_beat;

  assign ext_beat   = {t_last, t_id, t_dest, t_user, t_keep, t_strb, s_data};
  assign ext_accept = handshake(s_valid, s_ready);
  assign hold_cap   = ext_accept & ~p_ready;
  assign hold_rel   = hold_full & p_ready;

  axis_ready_reg u_rdy (
    .clk(clk), .rst(rst), .p_ready(p_ready), .s_ready(s_ready)
  );

  axis_hold_reg #(.W(BW)) u_hold (
    .clk(clk), .rst(rst), .cap(hold_cap), .rel(hold_rel),
    .d(ext_beat), .q(held_beat), .full(hold_full)
  );

  assign out_beat = hold_full ? held_beat : ext_beat;
  assign p_valid  = p_ready & (hold_full | ext_accept);
  assign {p_last, p_id, p_dest, p_user, p_keep, p_strb, p_data} = out_beat;

  assert_valid_gated_R1: assert property (@(posedge clk) disable iff (rst)
    !p_ready |-> !p_valid);
  assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    hold_full |-> !s_ready);
  assert_held_first_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_full && p_ready) |-> (p_valid && !ext_accept));
endmodule

// File: tb/axis_ingress_hold_test.sv
module axis_ingress_hold_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam int DSW = 4;
  localparam int UW = 2;
  localparam int LW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic [IW-1:0] s_id = '0;
  logic [DSW-1:0] s_dest = '0;
  logic [UW-1:0] s_user = '0;
  logic [LW-1:0] s_keep = '0;
  logic [LW-1:0] s_strb = '0;
  logic          p_ready = 1'b1;

  logic          s_ready, p_valid, p_last;
  logic [DW-1:0] p_data;
  logic [IW-1:0] p_id;
  logic [DSW-1:0] p_dest;
  logic [UW-1:0] p_user;
  logic [LW-1:0] p_keep, p_strb;

  logic          m_s_ready, m_p_valid, m_p_last;
  logic [DW-1:0] m_p_data;
  logic [IW-1:0] m_p_id;
  logic [DSW-1:0] m_p_dest;
  logic [UW-1:0] m_p_user;
  logic [LW-1:0] m_p_keep, m_p_strb;

  axis_ingress_hold #(.DATA_W(DW), .ID_W(IW), .DEST_W(DSW), .USER_W(UW)) uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_id(s_id), .s_dest(s_dest), .s_user(s_user), .s_keep(s_keep), .s_strb(s_strb),
    .s_ready(s_ready), .p_valid(p_valid), .p_data(p_data), .p_last(p_last),
    .p_id(p_id), .p_dest(p_dest), .p_user(p_user), .p_keep(p_keep), .p_strb(p_strb),
    .p_ready(p_ready));

  axis_ingress_hold #(.DATA_W(DW), .ID_W(IW), .DEST_W(DSW), .USER_W(UW),
    .USE_LAST(1'b0), .USE_ID(1'b0), .USE_DEST(1'b0), .USE_USER(1'b0),
    .USE_KEEP(1'b0), .USE_STRB(1'b0)) uut_min (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_id(s_id), .s_dest(s_dest), .s_user(s_user), .s_keep(s_keep), .s_strb(s_strb),
    .s_ready(m_s_ready), .p_valid(m_p_valid), .p_data(m_p_data), .p_last(m_p_last),
    .p_id(m_p_id), .p_dest(m_p_dest), .p_user(m_p_user), .p_keep(m_p_keep), .p_strb(m_p_strb),
    .p_ready(p_ready));

  int checks = 0;
  int failures = 0;
  logic exp_sready = 1'b1;
  logic [63:0] sb[$];
  int delivered = 0;

  function automatic logic [63:0] pack_in();
    return {13'd0, s_last, s_id, s_dest, s_user, s_keep, s_strb, s_data};
  endfunction

  function automatic logic [63:0] pack_out();
    return {13'd0, p_last, p_id, p_dest, p_user, p_keep, p_strb, p_data};
  endfunction

  // expected defaulted fields of the reduced instance: last=1, id/dest/user=0, keep/strb all ones
  function automatic logic [63:0] min_expect(input logic [DW-1:0] d);
    return {13'd0, 1'b1, {IW{1'b0}}, {DSW{1'b0}}, {UW{1'b0}}, {LW{1'b1}}, {LW{1'b1}}, d};
  endfunction

  function automatic logic [63:0] pack_min();
    return {13'd0, m_p_last, m_p_id, m_p_dest, m_p_user, m_p_keep, m_p_strb, m_p_data};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic pr);
    s_valid = v;
    s_data  = $urandom;
    s_last  = 1'($urandom);
    s_id    = IW'($urandom);
    s_dest  = DSW'($urandom);
    s_user  = UW'($urandom);
    s_keep  = LW'($urandom);
    s_strb  = LW'($urandom);
    p_ready = pr;
  endtask

  // observe current cycle, before the rising edge
  task automatic observe();
    logic [63:0] exp_b;
    if (!rst) begin
      check(s_ready == exp_sready, "R2", {63'd0, s_ready}, {63'd0, exp_sready});
      if (!p_ready) check(!p_valid, "R1", {63'd0, p_valid}, 64'd0);
      if (s_valid && s_ready) sb.push_back(pack_in());
      if (p_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6", pack_out(), 64'd0);
        end else begin
          exp_b = sb.pop_front();
          check(pack_out() == exp_b, "R6", pack_out(), exp_b);
          delivered++;
        end
      end
      if (m_p_valid) check(pack_min() == min_expect(m_p_data), "R7", pack_min(), min_expect(m_p_data));
      exp_sready = p_ready;
    end else begin
      exp_sready = 1'b1;
      sb.delete();
    end
  endtask

  task automatic step(input logic v, input logic pr);
    @(negedge clk);
    drive(v, pr);
    #1;
    observe();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h1d2c3b4a));
    rst = 1'b1;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    @(negedge clk); rst = 1'b0;
    #1;
    // R8: reset state
    check(s_ready == 1'b1, "R8", {63'd0, s_ready}, 64'd1);
    check(!p_valid, "R8", {63'd0, p_valid}, 64'd0);
    exp_sready = 1'b1;

    // R6: idle with s_valid low produces nothing
    step(1'b0, 1'b1);
    check(!p_valid, "R6", {63'd0, p_valid}, 64'd0);

    // R3: pass-through in same cycle
    step(1'b1, 1'b1);
    check(p_valid && pack_out() == pack_in(), "R3", pack_out(), pack_in());

    // R4: capture during the late-ready cycle
    step(1'b1, 1'b0);
    held = pack_in();
    check(s_ready == 1'b1 && !p_valid, "R4", {62'd0, s_ready, p_valid}, 64'd2);
    // R5: hold full keeps s_ready low across a long stall
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0);
      check(!s_ready, "R5", {63'd0, s_ready}, 64'd0);
    end
    // release: held beat first, s_ready still low
    step(1'b1, 1'b1);
    check(p_valid && pack_out() == held, "R4", pack_out(), held);
    check(!s_ready, "R4", {63'd0, s_ready}, 64'd0);
    step(1'b1, 1'b1);
    check(s_ready && p_valid, "R2", {62'd0, s_ready, p_valid}, 64'd3);

    // R8: reset while the holding register is full
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk); rst = 1'b1; drive(1'b0, 1'b1); #1; observe();
    @(negedge clk); rst = 1'b0; drive(1'b0, 1'b1); #1;
    check(!p_valid && s_ready, "R8", {62'd0, p_valid, s_ready}, 64'd1);
    exp_sready = 1'b1;
    observe();

    // random traffic with stalls
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 3) != 0);
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    check(sb.size() == 0, "R6", 64'(sb.size()), 64'd0);
    check(delivered > 1000, "R6", 64'(delivered), 64'd1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule